// File: doc/BRIEF.md
# Packed Lane Maximum/Minimum Selector

This block takes two 64-bit words, each holding four signed 16-bit lanes, and returns the lane-wise maximum or minimum of the pair. It does not choose with a per-lane multiplexer. Each lane comparator first produces a full-width mask: all ones when the lane of operand A is greater than the lane of operand B, and all zeros otherwise. The result is then built with bitwise logic only. The operand kept where the mask is set is ANDed with the mask, the other operand is ANDed with the inverted mask, and the two terms are ORed.

Max mode implements grey-scale dilation and min mode implements erosion. The raw lane mask is also driven out on the same cycle as the result. Downstream logic can use it as a threshold map for segmentation, or as one bound test of a box classifier. A word pair is accepted on any cycle where the input valid is high. The result and the mask appear one clock later, together with an output valid. An outer loop can issue two such words back to back to cover an eight-pixel step.

Top module: `lane_select_max`

## Requirements
- R1: While the active-low reset is held low, and on the first edge after it is released, out_valid, result and mask are all zero.
- R2: out_valid is high in exactly those cycles that follow a rising clock edge at which in_valid was high.
- R3: Lane i occupies bits [16*i+15 : 16*i] of op_a, op_b, result and mask. A mask lane is 16'hFFFF when the op_a lane is greater than the op_b lane and 16'h0000 otherwise, so equal lanes give 16'h0000.
- R4: With sel_min = 0, each result lane is the op_a lane where the mask lane is ones and the op_b lane otherwise. This is the signed maximum, and equal lanes return the op_b value.
- R5: With sel_min = 1, each result lane is the op_b lane where the mask lane is ones and the op_a lane otherwise. This is the signed minimum.
- R6: Lane values are compared as two's-complement numbers, so 16'h8000 is below every other value and 16'h7FFF is above every other value.
- R7: When in_valid is low at an edge, result and mask keep their previous values.
- R8: Each lane is computed only from the same lane of the two operands. Lanes with opposite compare outcomes in one word are each resolved correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| sel_min | input | 1 | 0 selects the lane maximum, 1 selects the lane minimum |
| op_a | input | 64 | First packed operand, four signed 16-bit lanes |
| op_b | input | 64 | Second packed operand, four signed 16-bit lanes |
| out_valid | output | 1 | result and mask are new this cycle |
| result | output | 64 | Lane-wise maximum or minimum |
| mask | output | 64 | Per-lane compare mask, all ones where op_a > op_b |

## Verification
The hardest cases to reach are words in which the lanes disagree. Examples are one lane equal, one at the signed extremes, and others split between A-greater and B-greater. Uniform random 16-bit values almost never give equal lanes or the 16'h8000/16'h7FFF pairs. For this reason the random generator draws each lane independently from a weighted pool of extreme values, copies of the other operand's lane, and free values. Directed words then place the sign-boundary pairs in different lanes in both modes.

// File: rtl/lane_select_max.sv
module lane_select_max #(
  parameter int LANES  = 4,
  parameter int LANE_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      sel_min,
  input  logic [LANES*LANE_W-1:0]   op_a,
  input  logic [LANES*LANE_W-1:0]   op_b,
  output logic                      out_valid,
  output logic [LANES*LANE_W-1:0]   result,
  output logic [LANES*LANE_W-1:0]   mask
);
  localparam int WORD_W = LANES * LANE_W;

  logic [WORD_W-1:0] gt_mask;
  logic [WORD_W-1:0] keep_a;
  logic [WORD_W-1:0] keep_b;
  logic [WORD_W-1:0] sel_word;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic gt;
    assign gt = $signed(op_a[i*LANE_W +: LANE_W]) > $signed(op_b[i*LANE_W +: LANE_W]);
    assign gt_mask[i*LANE_W +: LANE_W] = {LANE_W{gt}};
  end

  assign keep_a   = sel_min ? (op_a & ~gt_mask) : (op_a & gt_mask);
  assign keep_b   = sel_min ? (op_b & gt_mask)  : (op_b & ~gt_mask);
  assign sel_word = keep_a | keep_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      mask      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= sel_word;
        mask   <= gt_mask;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(mask))); // R7

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    AST_LANE_FROM_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (result[i*LANE_W +: LANE_W] == $past(op_a[i*LANE_W +: LANE_W]) ||
                    result[i*LANE_W +: LANE_W] == $past(op_b[i*LANE_W +: LANE_W]))); // R8
    AST_MAX_NOT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !sel_min) |=> ($signed(result[i*LANE_W +: LANE_W]) >= $signed($past(op_a[i*LANE_W +: LANE_W])) &&
                                  $signed(result[i*LANE_W +: LANE_W]) >= $signed($past(op_b[i*LANE_W +: LANE_W])))); // R4
    AST_MIN_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sel_min) |=> ($signed(result[i*LANE_W +: LANE_W]) <= $signed($past(op_a[i*LANE_W +: LANE_W])) &&
                                 $signed(result[i*LANE_W +: LANE_W]) <= $signed($past(op_b[i*LANE_W +: LANE_W])))); // R5
    AST_MASK_SOLID: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (mask[i*LANE_W +: LANE_W] == '0 || mask[i*LANE_W +: LANE_W] == '1)); // R3
  end
endmodule

// File: tb/lane_select_max_tb.sv
module lane_select_max_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int LW = 16;
  localparam int WW = LANES * LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic sel_min = 1'b0;
  logic [WW-1:0] op_a = '0;
  logic [WW-1:0] op_b = '0;
  logic out_valid;
  logic [WW-1:0] result;
  logic [WW-1:0] mask;

  int checks = 0;
  int errors = 0;
  logic [WW-1:0] exp_res = '0;
  logic [WW-1:0] exp_msk = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_select_max u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sel_min(sel_min),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result), .mask(mask)
  );

  function automatic logic [WW-1:0] ref_mask(input logic [WW-1:0] a, input logic [WW-1:0] b);
    logic [WW-1:0] m;
    for (int i = 0; i < LANES; i++) begin
      int sa = $signed(a[i*LW +: LW]);
      int sb = $signed(b[i*LW +: LW]);
      m[i*LW +: LW] = (sa > sb) ? 16'hFFFF : 16'h0000;
    end
    return m;
  endfunction

  function automatic logic [WW-1:0] ref_sel(input logic [WW-1:0] a, input logic [WW-1:0] b, input logic mn);
    logic [WW-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      int sa = $signed(a[i*LW +: LW]);
      int sb = $signed(b[i*LW +: LW]);
      if (!mn) r[i*LW +: LW] = (sa > sb) ? a[i*LW +: LW] : b[i*LW +: LW];
      else     r[i*LW +: LW] = (sa > sb) ? b[i*LW +: LW] : a[i*LW +: LW];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic mn, input logic [WW-1:0] a,
                      input logic [WW-1:0] b, input string req);
    @(negedge clk);
    in_valid = v; sel_min = mn; op_a = a; op_b = b;
    if (v) begin
      exp_res = ref_sel(a, b, mn);
      exp_msk = ref_mask(a, b);
    end
    @(posedge clk);
    #1;
    check({"R2 ", req}, {63'd0, out_valid}, {63'd0, v});
    check({req, " result"}, result, exp_res);
    check({"R3 ", req, " mask"}, mask, exp_msk);
  endtask

  function automatic logic [LW-1:0] pick_lane(input logic [LW-1:0] other);
    int k = $urandom_range(0, 9);
    case (k)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'h0000;
      3: return 16'hFFFF;
      4, 5: return other;
      default: return LW'($urandom);
    endcase
  endfunction

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid", {63'd0, out_valid}, '0);
    check("R1 result", result, '0);
    check("R1 mask", mask, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 first edge", {63'd0, out_valid}, '0);

    // R4 max with equal lane selecting B (lane0 equal)
    step(1, 0, 64'h0005_0003_FFFF_1234, 64'h0002_0009_0001_1234, "R4 max mixed");
    // R5 min on same word
    step(1, 1, 64'h0005_0003_FFFF_1234, 64'h0002_0009_0001_1234, "R5 min mixed");
    // R6 sign extremes in differing lanes
    step(1, 0, 64'h8000_7FFF_0000_FFFF, 64'h7FFF_8000_8000_0000, "R6 max extremes");
    step(1, 1, 64'h8000_7FFF_0000_FFFF, 64'h7FFF_8000_8000_0000, "R6 min extremes");
    // R8 lane independence: only lane 2 has A greater
    step(1, 0, 64'h0000_0100_0000_0000, 64'h0001_0000_0001_0001, "R8 isolated lane");
    // R7 idle cycles with changing inputs
    step(0, 1, 64'h7FFF_7FFF_7FFF_7FFF, 64'h8000_8000_8000_8000, "R7 idle hold");
    step(0, 0, 64'h1111_2222_3333_4444, 64'h0, "R7 idle hold2");
    // R3 all equal -> zero mask
    step(1, 0, 64'hABCD_ABCD_ABCD_ABCD, 64'hABCD_ABCD_ABCD_ABCD, "R3 all equal");

    for (int n = 0; n < 400; n++) begin
      logic [WW-1:0] a, b;
      logic v, mn;
      for (int i = 0; i < LANES; i++) begin
        b[i*LW +: LW] = LW'($urandom);
        a[i*LW +: LW] = pick_lane(b[i*LW +: LW]);
        if ($urandom_range(0, 1) == 1) b[i*LW +: LW] = pick_lane(a[i*LW +: LW]);
      end
      v  = ($urandom_range(0, 3) != 0);
      mn = $urandom_range(0, 1) == 1;
      step(v, mn, a, b, mn ? "R5 random" : "R4 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule